// File: doc/BRIEF.md
# Eight-Stream TDM Serial Receiver with Channel Store

The block takes in eight serial time-division streams. All eight share one frame timing. Each stream carries 32 channels of 8 bits per 125 us frame. The block is clocked by a bit clock at twice the bit rate (4.096 MHz for 2.048 Mb/s streams), so one bit cell lasts two clock cycles and one frame lasts 512 cycles. A frame bit counter runs freely on the falling edge of that clock. An active-low frame pulse forces the counter back to channel 0, bit 7. From the counter the block exports the current channel number, the bit index and the half-cell phase, so that the transmit and control logic nearby can run on the same timing.

The eight streams are sampled together, once per bit cell, most significant bit first. When a channel word is complete on all streams, the eight words are copied into a holding bank. They are then written one at a time into a 256 x 8 store. The store is addressed by {stream, channel}. It has two read ports. The switching-engine port is combinational. The host port is registered and has one clock of latency.

Top module: `tdm_rx`

## Requirements
- R1: While rst_ni is low, the counter reads channel 0, bit index 7, phase 0, and every store location reads 0 on both read ports.
- R2: Each falling clock edge advances the counter by one half cell. phase_o toggles 0 then 1. bit_index_o steps 7 down to 0 once per cell. chan_o steps once per 8 cells. After channel 31, bit 0, phase 1, the counter wraps to channel 0, bit 7, phase 0, so one frame is 512 edges.
- R3: A falling edge at which fp_ni is sampled low loads the counter to channel 0, bit index 7, phase 0.
- R4: Each stream is sampled at the falling edge that ends phase 0 of a bit cell. The first cell of a channel carries bit 7 and the last cell carries bit 0. The word for stream s, channel c is stored at address {s, c}: address bits [7:5] hold the stream and bits [4:0] hold the channel.
- R5: Take edge 0 as the falling edge after which the outputs read channel c, bit index 0, phase 1. The new word for stream s, channel c becomes readable after edge s+1. Before that edge, the previous contents are read. The streams are written in order 0 to 7, one per edge.
- R6: sw_data_o shows the store word at sw_addr_i in the same cycle. host_data_o shows the store word at the host_addr_i value that was sampled at the previous falling edge.
- R7: After a frame pulse realigns the counter in mid-frame, words received afterwards are stored under the channel numbering of the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate bit clock; all state changes on its falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fp_ni | input | 1 | Active-low frame pulse |
| st_i | input | 8 | Serial input streams, bit s = stream s |
| chan_o | output | 5 | Current channel number |
| bit_index_o | output | 3 | Current bit index in the channel (7 = first) |
| phase_o | output | 1 | Half-cell phase (0 = first half) |
| sw_addr_i | input | 8 | Switching-engine read address {stream, channel} |
| sw_data_o | output | 8 | Combinational read data |
| host_addr_i | input | 8 | Host read address {stream, channel} |
| host_data_o | output | 8 | Registered read data, one cycle latency |

## Verification
A counter that slips shows up at once on chan_o, bit_index_o and phase_o, and the bench compares these on every cycle. A wrong sampling phase, a wrong bit order or a wrong stream-to-address mapping shows up as bad data across the whole store. This is seen by a full scan of both read ports after two frames of repeating random data. A holding-bank or write-sequencer fault moves the moment a word appears. A directed test reads all eight streams of one channel on each of the nine edges after the word completes, so an error of even a single cycle is reported.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int unsigned NUM_STREAMS = 8;
  localparam int unsigned NUM_CHANS   = 32;
  localparam int unsigned WORD_BITS   = 8;
endpackage

// File: rtl/tdm_rx_timing.sv
module tdm_rx_timing #(
  parameter int unsigned N_CH   = 32,
  parameter int unsigned WORD_W = 8,
  localparam int unsigned CH_W  = $clog2(N_CH),
  localparam int unsigned POS_W = $clog2(WORD_W),
  localparam int unsigned CNT_W = CH_W + POS_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fp_ni,
  output logic [CH_W-1:0]  chan_o,
  output logic [POS_W-1:0] pos_o,
  output logic             phase_o,
  output logic             sample_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!fp_ni) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign phase_o  = cnt_q[0];
  assign pos_o    = cnt_q[POS_W:1];
  assign chan_o   = cnt_q[CNT_W-1:POS_W+1];
  // next edge ends phase 0: that edge samples the wire
  assign sample_o = ~cnt_q[0];
  assign done_o   = sample_o & (&pos_o);
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser #(
  parameter int unsigned N_STR  = 8,
  parameter int unsigned N_CH   = 32,
  parameter int unsigned WORD_W = 8,
  localparam int unsigned STR_W = $clog2(N_STR),
  localparam int unsigned CH_W  = $clog2(N_CH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [N_STR-1:0]      st_i,
  input  logic                  sample_i,
  input  logic                  done_i,
  input  logic [CH_W-1:0]       chan_i,
  output logic                  wr_en_o,
  output logic [STR_W+CH_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0]     wr_data_o
);
  logic [WORD_W-1:0] hold_q [N_STR];
  logic [STR_W-1:0]  idx_q;
  logic [CH_W-1:0]   wch_q;
  logic              busy_q;

  for (genvar s = 0; s < N_STR; s++) begin : g_lane
    logic [WORD_W-1:0] sr_q;
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sr_q      <= '0;
        hold_q[s] <= '0;
      end else if (sample_i) begin
        sr_q <= {sr_q[WORD_W-2:0], st_i[s]};
        if (done_i) hold_q[s] <= {sr_q[WORD_W-2:0], st_i[s]};
      end
    end
  end

  // drain the holding bank one stream per edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      wch_q  <= '0;
    end else if (done_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      wch_q  <= chan_i;
    end else if (busy_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == STR_W'(N_STR - 1)) busy_q <= 1'b0;
    end
  end

  assign wr_en_o   = busy_q;
  assign wr_addr_o = {idx_q, wch_q};
  assign wr_data_o = hold_q[idx_q];
endmodule

// File: rtl/tdm_rx_dmem.sv
module tdm_rx_dmem #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned WORD_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] ra_addr_i,
  output logic [WORD_W-1:0] ra_data_o,
  input  logic [ADDR_W-1:0] rb_addr_i,
  output logic [WORD_W-1:0] rb_data_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [WORD_W-1:0] rb_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rb_q <= '0;
    else         rb_q <= mem_q[rb_addr_i];
  end

  assign ra_data_o = mem_q[ra_addr_i];
  assign rb_data_o = rb_q;
endmodule

// File: rtl/tdm_rx.sv
module tdm_rx
  import tdm_rx_pkg::*;
#(
  parameter int unsigned N_STR  = NUM_STREAMS,
  parameter int unsigned N_CH   = NUM_CHANS,
  parameter int unsigned WORD_W = WORD_BITS,
  localparam int unsigned STR_W  = $clog2(N_STR),
  localparam int unsigned CH_W   = $clog2(N_CH),
  localparam int unsigned POS_W  = $clog2(WORD_W),
  localparam int unsigned ADDR_W = STR_W + CH_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fp_ni,
  input  logic [N_STR-1:0]  st_i,
  output logic [CH_W-1:0]   chan_o,
  output logic [POS_W-1:0]  bit_index_o,
  output logic              phase_o,
  input  logic [ADDR_W-1:0] sw_addr_i,
  output logic [WORD_W-1:0] sw_data_o,
  input  logic [ADDR_W-1:0] host_addr_i,
  output logic [WORD_W-1:0] host_data_o
);
  logic [POS_W-1:0]  pos_w;
  logic              sample_w, done_w;
  logic              wr_en_w;
  logic [ADDR_W-1:0] wr_addr_w;
  logic [WORD_W-1:0] wr_data_w;

  tdm_rx_timing #(.N_CH(N_CH), .WORD_W(WORD_W)) u_timing (
    .clk_i, .rst_ni, .fp_ni,
    .chan_o, .pos_o(pos_w), .phase_o,
    .sample_o(sample_w), .done_o(done_w)
  );

  assign bit_index_o = ~pos_w;

  tdm_rx_deser #(.N_STR(N_STR), .N_CH(N_CH), .WORD_W(WORD_W)) u_deser (
    .clk_i, .rst_ni, .st_i,
    .sample_i(sample_w), .done_i(done_w), .chan_i(chan_o),
    .wr_en_o(wr_en_w), .wr_addr_o(wr_addr_w), .wr_data_o(wr_data_w)
  );

  tdm_rx_dmem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dmem (
    .clk_i, .rst_ni,
    .we_i(wr_en_w), .waddr_i(wr_addr_w), .wdata_i(wr_data_w),
    .ra_addr_i(sw_addr_i), .ra_data_o(sw_data_o),
    .rb_addr_i(host_addr_i), .rb_data_o(host_data_o)
  );
endmodule

// File: rtl/tdm_rx_chk.sv
module tdm_rx_chk #(
  parameter int unsigned CH_W   = 5,
  parameter int unsigned POS_W  = 3,
  parameter int unsigned STR_W  = 3,
  parameter int unsigned WORD_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  fp_ni,
  input logic [CH_W-1:0]       chan_o,
  input logic [POS_W-1:0]      bit_index_o,
  input logic                  phase_o,
  input logic                  wr_en,
  input logic [STR_W+CH_W-1:0] wr_addr,
  input logic [STR_W+CH_W-1:0] sw_addr_i,
  input logic [WORD_W-1:0]     sw_data_o,
  input logic [STR_W+CH_W-1:0] host_addr_i,
  input logic [WORD_W-1:0]     host_data_o
);
  assert_phase_toggle_R2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    fp_ni |=> (phase_o != $past(phase_o)));

  assert_bit_step_R2: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (fp_ni && phase_o) |=> (bit_index_o == POS_W'($past(bit_index_o) - 1'b1)));

  assert_realign_R3: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !fp_ni |=> (chan_o == '0 && (&bit_index_o) && !phase_o));

  assert_write_start_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (fp_ni && bit_index_o == '0 && !phase_o) |=>
      (wr_en && wr_addr[STR_W+CH_W-1:CH_W] == '0 && wr_addr[CH_W-1:0] == $past(chan_o)));

  assert_write_order_R5: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (wr_en && !(&wr_addr[STR_W+CH_W-1:CH_W]) && !(fp_ni && bit_index_o == '0 && !phase_o)) |=>
      (wr_en && wr_addr[STR_W+CH_W-1:CH_W] == STR_W'($past(wr_addr[STR_W+CH_W-1:CH_W]) + 1'b1)));

  assert_host_latency_R6: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (host_addr_i == sw_addr_i && !wr_en) |=> (host_data_o == $past(sw_data_o)));
endmodule

bind tdm_rx tdm_rx_chk #(.CH_W(CH_W), .POS_W(POS_W), .STR_W(STR_W), .WORD_W(WORD_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fp_ni(fp_ni),
  .chan_o(chan_o), .bit_index_o(bit_index_o), .phase_o(phase_o),
  .wr_en(wr_en_w), .wr_addr(wr_addr_w),
  .sw_addr_i(sw_addr_i), .sw_data_o(sw_data_o),
  .host_addr_i(host_addr_i), .host_data_o(host_data_o)
);

// File: tb/tdm_rx_bench.sv
`timescale 1ns/1ps
module tdm_rx_bench;
  localparam int PERIOD = 244;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       fp_ni = 1'b1;
  logic [7:0] st_i = '0;
  logic [4:0] chan_o;
  logic [2:0] bit_index_o;
  logic       phase_o;
  logic [7:0] sw_addr_i = '0, sw_data_o;
  logic [7:0] host_addr_i = '0, host_data_o;

  int checks = 0, errors = 0;
  bit tim_en = 1'b0;
  string tim_tag = "R2";
  logic [8:0] mcnt = '0;
  logic [7:0] tx [8][32];

  tdm_rx u_tdm_rx (
    .clk_i(clk), .rst_ni, .fp_ni, .st_i,
    .chan_o, .bit_index_o, .phase_o,
    .sw_addr_i, .sw_data_o, .host_addr_i, .host_data_o
  );

  always #(PERIOD/2) clk = ~clk;

  // frame counter model
  always @(negedge clk or negedge rst_ni) begin
    if (!rst_ni)     mcnt <= '0;
    else if (!fp_ni) mcnt <= '0;
    else             mcnt <= mcnt + 9'd1;
  end

  function automatic logic line_bit(int s, logic [8:0] c);
    return tx[s][c[8:4]][7 - int'(c[3:1])];
  endfunction

  // line driver: wire holds the bit of the current cell
  initial forever begin
    @(posedge clk);
    for (int s = 0; s < 8; s++) st_i[s] = line_bit(s, mcnt);
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    if (tim_en) begin
      chk({tim_tag, " chan"}, chan_o, mcnt[8:4]);
      chk({tim_tag, " bit"}, bit_index_o, 7 - int'(mcnt[3:1]));
      chk({tim_tag, " phase"}, phase_o, mcnt[0]);
    end
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic fill_random();
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 32; c++) tx[s][c] = 8'($urandom);
  endtask

  // full scan of both read ports while the same frame keeps arriving
  task automatic scan(string tag);
    logic [7:0] prev;
    for (int a = 0; a <= 256; a++) begin
      step();
      if (a > 0) chk({tag, " host"}, host_data_o, tx[prev[7:5]][prev[4:0]]);
      if (a < 256) begin
        prev        = 8'(a);
        host_addr_i = 8'(a);
        sw_addr_i   = 8'(255 - a);
        #1 chk({tag, " sw"}, sw_data_o, tx[sw_addr_i[7:5]][sw_addr_i[4:0]]);
      end
    end
  endtask

  task automatic pulse();
    step(); fp_ni = 1'b0;
    step(); fp_ni = 1'b1;
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 32; c++) tx[s][c] = '0;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk("R1 chan", chan_o, 0);
    chk("R1 bit", bit_index_o, 7);
    chk("R1 phase", phase_o, 0);
    for (int i = 0; i < 6; i++) begin
      sw_addr_i   = 8'($urandom);
      host_addr_i = 8'($urandom);
      #1 chk("R1 sw", sw_data_o, 0);
      chk("R1 host", host_data_o, 0);
    end
    rst_ni = 1'b1;

    // R2: free-run across a frame wrap
    tim_en = 1'b1;
    steps(600);

    // R3: realignment at an arbitrary point
    steps(77);
    pulse();
    chk("R3 chan", chan_o, 0);
    chk("R3 bit", bit_index_o, 7);
    chk("R3 phase", phase_o, 0);
    steps(20);

    // R4/R6: random frames, repeated, then full scans
    for (int r = 0; r < 2; r++) begin
      fill_random();
      steps(1100);
      scan("R4 R6");
    end

    // R7: mid-frame realignment, then data must follow the new numbering
    fill_random();
    steps(300 + int'($urandom % 200));
    tim_tag = "R3";
    pulse();
    tim_tag = "R2";
    steps(1100);
    scan("R7");

    // R5: write order and timing for one channel
    begin
      logic [7:0] oldv [8];
      logic [7:0] newv [8];
      while (mcnt[8:4] != 5'd2) step();
      for (int s = 0; s < 8; s++) begin
        oldv[s]  = tx[s][5];
        newv[s]  = ~tx[s][5] ^ 8'(s);
        tx[s][5] = newv[s];
      end
      step();
      while (!(chan_o == 5'd5 && bit_index_o == 3'd0 && phase_o)) step();
      for (int k = 0; k <= 8; k++) begin
        for (int s = 0; s < 8; s++) begin
          sw_addr_i = {3'(s), 5'd5};
          #1 chk("R5 write order", sw_data_o, (s < k) ? newv[s] : oldv[s]);
        end
        if (k < 8) step();
      end
    end
    steps(50);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule